// File: doc/BRIEF.md
# Write-Combining Store Writeback Buffer

This block sits between the retirement stage of a processor and the data cache. It holds stores that have already retired but whose cache update has not happened yet. Once the buffer accepts a store, that store counts as committed, even if the cache would later miss on it. The buffer therefore belongs to the architectural memory state. It drains one line entry at a time, oldest first, through a valid/ready write port into the cache. An entry is released only after the cache takes it.

Each entry covers one cache line. It holds the line address, the line data and one valid bit per byte. A store whose address lies inside a parameterised write-combinable window can fold into the youngest buffered entry for the same line. Only the bytes that the store enables are overwritten, so several stores become one cache write. The entry currently offered to the cache is never modified. A load probe searches all entries in the same cycle and forwards from the youngest entry that holds the requested line. If that entry lacks any requested byte, the probe signals retry instead of a hit.

Addresses on the store and load ports are word addresses, that is, the byte address divided by four. Words are 4 bytes and lines are 16 bytes. The cache port carries the line number, which is the byte address divided by 16.

Top module: `store_combine_buf`

## Requirements
- R1: After reset the buffer is empty: cw_valid is 0, st_ready is 1, and ld_hit and ld_retry are 0.
- R2: A store is taken on a cycle with st_valid and st_ready both high. Entries are offered on the cache port in the order they were allocated, each exactly once.
- R3: While cw_valid is high and cw_ready is low, cw_line, cw_data and cw_mask do not change. The offered entry is gone from the buffer in the cycle after it is accepted.
- R4: st_ready is low only when all DEPTH entries are occupied and the incoming store cannot be merged. A mergeable store is taken even when the buffer is full.
- R5: A store is merged instead of allocated when three conditions hold:
  - its byte address lies in [WC_LO, WC_HI];
  - a buffered entry holds the same line;
  - the youngest such entry is not the one offered to the cache.

  Byte b of the store word (data bits 8b+7:8b, enabled by st_mask[b]) at word index w (word address bits 1:0) lands in line byte 4w+b, both in data and in mask bit 4w+b. No other byte of the entry changes.
- R6: The entry offered on the cache port is never merged into. A store to its line opens a new entry.
- R7: A store outside [WC_LO, WC_HI] always opens a new entry, even when its line is already buffered.
- R8: A load probe selects the youngest entry holding its line. If that entry has every byte in ld_mask valid, ld_hit is 1 and ld_data returns that entry's word, in the same cycle.
- R9: If the selected entry lacks any byte enabled in ld_mask, ld_retry is 1 and ld_hit is 0.
- R10: If no entry holds the line, both ld_hit and ld_retry are 0 and ld_data is 0.
- R11: An entry keeps forwarding to loads up to and including the cycle in which the cache accepts it, and no longer after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Retired store offered |
| st_ready | output | 1 | Store taken this cycle if valid |
| st_waddr | input | 30 | Store word address |
| st_data | input | 32 | Store word data |
| st_mask | input | 4 | Store byte enables |
| ld_waddr | input | 30 | Load probe word address |
| ld_mask | input | 4 | Load probe byte enables |
| ld_hit | output | 1 | All requested bytes forwarded |
| ld_retry | output | 1 | Line buffered but bytes incomplete |
| ld_data | output | 32 | Forwarded word |
| cw_valid | output | 1 | Oldest entry offered to cache |
| cw_ready | input | 1 | Cache accepts the offered entry |
| cw_line | output | 28 | Line number of offered entry |
| cw_data | output | 128 | Line data of offered entry |
| cw_mask | output | 16 | Byte valid mask of offered entry |

## Verification
The checker assumes the cache never withdraws a write it has not yet accepted. It also assumes the write-combinable window starts and ends on line boundaries, so that every entry for a given line falls on the same side of the window. The bench respects both: it drives cw_ready only as a level and picks window bounds and store addresses on whole lines. It keeps cw_ready low while it fills the buffer, so the merge, locking and full-stall cases meet a known head entry. It then opens the cache port to compare the drained lines, in order, with its own model of the expected entries.

// File: rtl/scb_pkg.sv
`timescale 1ns/1ps
package scb_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int LINE_BYTES = 16;

    localparam int BSEL_W  = $clog2(WORD_BYTES);
    localparam int WPL     = LINE_BYTES / WORD_BYTES;
    localparam int WIDX_W  = $clog2(WPL);
    localparam int WA_W    = ADDR_W - BSEL_W;
    localparam int LINE_W  = WA_W - WIDX_W;
    localparam int WORD_W  = 8 * WORD_BYTES;
    localparam int LDATA_W = 8 * LINE_BYTES;

    typedef logic [LINE_W-1:0] line_addr_t;

    typedef struct packed {
        line_addr_t          line;
        logic [LDATA_W-1:0]  data;
        logic [LINE_BYTES-1:0] mask;
    } slot_t;

    typedef struct packed {
        line_addr_t        line;
        logic [WIDX_W-1:0] widx;
    } word_loc_t;

    function automatic word_loc_t locate(input logic [WA_W-1:0] wa);
        word_loc_t r;
        r.line = wa[WA_W-1:WIDX_W];
        r.widx = wa[WIDX_W-1:0];
        return r;
    endfunction

    // Write enabled bytes of one word into a line slot.
    function automatic slot_t overlay(input slot_t base,
                                      input logic [WIDX_W-1:0] widx,
                                      input logic [WORD_W-1:0] wdata,
                                      input logic [WORD_BYTES-1:0] wmask);
        slot_t r;
        r = base;
        for (int w = 0; w < WPL; w++) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
                if (w == int'(widx) && wmask[b]) begin
                    r.data[8*(w*WORD_BYTES+b) +: 8] = wdata[8*b +: 8];
                    r.mask[w*WORD_BYTES+b]          = 1'b1;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] word_data(input slot_t s,
                                                    input logic [WIDX_W-1:0] widx);
        return s.data[WORD_W*widx +: WORD_W];
    endfunction

    function automatic logic [WORD_BYTES-1:0] word_mask(input slot_t s,
                                                        input logic [WIDX_W-1:0] widx);
        return s.mask[WORD_BYTES*widx +: WORD_BYTES];
    endfunction
endpackage

// File: rtl/scb_line_match.sv
`timescale 1ns/1ps
module scb_line_match
    import scb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] slot_live,
    input  line_addr_t       slot_line [DEPTH],
    input  line_addr_t       probe,
    output logic [DEPTH-1:0] hits
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hits[i] = slot_live[i] && (slot_line[i] == probe);
    end
endmodule

// File: rtl/scb_youngest_pick.sv
`timescale 1ns/1ps
module scb_youngest_pick #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] hits,
    input  logic [PTR_W-1:0] head,
    output logic             found,
    output logic [PTR_W-1:0] idx
);
    // Walk from oldest to youngest; the last match seen is the youngest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [PTR_W-1:0] p;
            p = head + PTR_W'(i);
            if (hits[p]) begin
                found = 1'b1;
                idx   = p;
            end
        end
    end
endmodule

// File: rtl/store_combine_buf.sv
`timescale 1ns/1ps
module store_combine_buf
    import scb_pkg::*;
#(
    parameter int                DEPTH = 8,          // power of two, >= 2
    parameter logic [ADDR_W-1:0] WC_LO = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] WC_HI = 32'h0000_1FFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [WA_W-1:0]       st_waddr,
    input  logic [WORD_W-1:0]     st_data,
    input  logic [WORD_BYTES-1:0] st_mask,
    input  logic [WA_W-1:0]       ld_waddr,
    input  logic [WORD_BYTES-1:0] ld_mask,
    output logic                  ld_hit,
    output logic                  ld_retry,
    output logic [WORD_W-1:0]     ld_data,
    output logic                  cw_valid,
    input  logic                  cw_ready,
    output logic [LINE_W-1:0]     cw_line,
    output logic [LDATA_W-1:0]    cw_data,
    output logic [LINE_BYTES-1:0] cw_mask
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    slot_t             slots [DEPTH];
    line_addr_t        slot_line [DEPTH];
    logic [DEPTH-1:0]  live;
    logic [PTR_W-1:0]  head, tail;
    logic [OCC_W-1:0]  occ;

    for (genvar i = 0; i < DEPTH; i++) begin : g_line
        assign slot_line[i] = slots[i].line;
    end

    // ---------------- store side ----------------
    word_loc_t        st_loc;
    logic [DEPTH-1:0] st_hits;
    logic             st_found;
    logic [PTR_W-1:0] st_idx;
    logic             in_wc, can_merge, full, take, alloc, pop;
    slot_t            fresh;

    assign st_loc = locate(st_waddr);

    scb_line_match #(.DEPTH(DEPTH)) u_st_match (
        .slot_live (live),
        .slot_line (slot_line),
        .probe     (st_loc.line),
        .hits      (st_hits)
    );

    scb_youngest_pick #(.DEPTH(DEPTH)) u_st_pick (
        .hits  (st_hits),
        .head  (head),
        .found (st_found),
        .idx   (st_idx)
    );

    always_comb begin
        in_wc     = ({st_waddr, {BSEL_W{1'b0}}} >= WC_LO) &&
                    ({st_waddr, {BSEL_W{1'b0}}} <= WC_HI);
        can_merge = in_wc && st_found && (st_idx != head);
        full      = (occ == OCC_W'(DEPTH));
        st_ready  = can_merge || !full;
        take      = st_valid && st_ready;
        alloc     = take && !can_merge;
        fresh     = '0;
        fresh.line = st_loc.line;
    end

    // ---------------- drain side ----------------
    assign cw_valid = live[head];
    assign cw_line  = slots[head].line;
    assign cw_data  = slots[head].data;
    assign cw_mask  = slots[head].mask;
    assign pop      = cw_valid && cw_ready;

    // ---------------- load probe ----------------
    word_loc_t        ld_loc;
    logic [DEPTH-1:0] ld_hits;
    logic             ld_found;
    logic [PTR_W-1:0] ld_idx;
    logic             covers;

    assign ld_loc = locate(ld_waddr);

    scb_line_match #(.DEPTH(DEPTH)) u_ld_match (
        .slot_live (live),
        .slot_line (slot_line),
        .probe     (ld_loc.line),
        .hits      (ld_hits)
    );

    scb_youngest_pick #(.DEPTH(DEPTH)) u_ld_pick (
        .hits  (ld_hits),
        .head  (head),
        .found (ld_found),
        .idx   (ld_idx)
    );

    always_comb begin
        covers   = (word_mask(slots[ld_idx], ld_loc.widx) & ld_mask) == ld_mask;
        ld_hit   = ld_found && covers;
        ld_retry = ld_found && !covers;
        ld_data  = ld_hit ? word_data(slots[ld_idx], ld_loc.widx) : '0;
    end

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
            live <= '0;
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (take) begin
                if (can_merge) begin
                    slots[st_idx] <= overlay(slots[st_idx], st_loc.widx, st_data, st_mask);
                end else begin
                    slots[tail] <= overlay(fresh, st_loc.widx, st_data, st_mask);
                    live[tail]  <= 1'b1;
                    tail        <= tail + 1'b1;
                end
            end
            if (pop) begin
                live[head] <= 1'b0;
                head       <= head + 1'b1;
            end
            occ <= occ + OCC_W'(alloc) - OCC_W'(pop);
        end
    end
endmodule

// File: rtl/scb_checker.sv
`timescale 1ns/1ps
module scb_checker
    import scb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  st_ready,
    input logic                  ld_hit,
    input logic                  ld_retry,
    input logic                  cw_valid,
    input logic                  cw_ready,
    input logic [LINE_W-1:0]     cw_line,
    input logic [LDATA_W-1:0]    cw_data,
    input logic [LINE_BYTES-1:0] cw_mask,
    input logic [OCC_W-1:0]      occ
);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_line) &&
                                     $stable(cw_data) && $stable(cw_mask)));

    // R4
    stall_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        !st_ready |-> (occ == OCC_W'(DEPTH)));

    // R9
    hit_retry_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_hit && ld_retry));

    // R10
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> (!cw_valid && !ld_hit && !ld_retry));
endmodule

bind store_combine_buf scb_checker #(.DEPTH(DEPTH)) u_scb_chk (
    .clk      (clk),
    .rst      (rst),
    .st_ready (st_ready),
    .ld_hit   (ld_hit),
    .ld_retry (ld_retry),
    .cw_valid (cw_valid),
    .cw_ready (cw_ready),
    .cw_line  (cw_line),
    .cw_data  (cw_data),
    .cw_mask  (cw_mask),
    .occ      (occ)
);

// File: tb/store_combine_buf_bench.sv
`timescale 1ns/1ps
module store_combine_buf_bench;
    import scb_pkg::*;

    localparam logic [31:0] LO = 32'h0000_1000;
    localparam logic [31:0] HI = 32'h0000_1FFF;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  st_valid = 1'b0;
    logic                  st_ready;
    logic [WA_W-1:0]       st_waddr = '0;
    logic [WORD_W-1:0]     st_data = '0;
    logic [WORD_BYTES-1:0] st_mask = '0;
    logic [WA_W-1:0]       ld_waddr = '0;
    logic [WORD_BYTES-1:0] ld_mask = '0;
    logic                  ld_hit, ld_retry;
    logic [WORD_W-1:0]     ld_data;
    logic                  cw_valid;
    logic                  cw_ready = 1'b0;
    logic [LINE_W-1:0]     cw_line;
    logic [LDATA_W-1:0]    cw_data;
    logic [LINE_BYTES-1:0] cw_mask;

    int total = 0;
    int fails = 0;
    slot_t exp_q[$];

    always #2 clk = ~clk;

    store_combine_buf #(.DEPTH(8), .WC_LO(LO), .WC_HI(HI)) u_store_combine_buf (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_waddr(st_waddr),
        .st_data(st_data), .st_mask(st_mask),
        .ld_waddr(ld_waddr), .ld_mask(ld_mask),
        .ld_hit(ld_hit), .ld_retry(ld_retry), .ld_data(ld_data),
        .cw_valid(cw_valid), .cw_ready(cw_ready),
        .cw_line(cw_line), .cw_data(cw_data), .cw_mask(cw_mask)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [159:0] act, input logic [159:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Driver: offer a store, wait for it, update the expected-entry model.
    task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] m);
        int    y;
        bit    wc;
        slot_t e;
        @(posedge clk); #1;
        st_valid = 1'b1; st_waddr = a[31:2]; st_data = d; st_mask = m;
        @(negedge clk);
        while (!st_ready) @(negedge clk);
        y = -1;
        for (int i = 0; i < exp_q.size(); i++)
            if (exp_q[i].line == a[31:4]) y = i;
        wc = (a >= LO) && (a <= HI);
        if (wc && y > 0) e = exp_q[y];
        else begin e = '0; e.line = a[31:4]; end
        for (int b = 0; b < 4; b++) begin
            if (m[b]) begin
                e.data[8*(4*int'(a[3:2])+b) +: 8] = d[8*b +: 8];
                e.mask[4*int'(a[3:2])+b] = 1'b1;
            end
        end
        if (wc && y > 0) exp_q[y] = e;
        else exp_q.push_back(e);
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic [3:0] m, input bit eh,
                         input bit er, input logic [31:0] ed, input string req);
        @(posedge clk); #1;
        ld_waddr = a[31:2]; ld_mask = m;
        @(negedge clk);
        chk(ld_hit == eh && ld_retry == er && ld_data == ed, req,
            {ld_hit, ld_retry, ld_data}, {eh, er, ed});
    endtask

    // Monitor: compare each accepted cache write with the oldest expected entry.
    always @(negedge clk) begin
        if (!rst && cw_valid && cw_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected write", {cw_line, cw_mask}, '0);
            end else begin
                chk(cw_line == exp_q[0].line && cw_data == exp_q[0].data &&
                    cw_mask == exp_q[0].mask, "R2 drain order/content",
                    {cw_line, cw_mask, cw_data[31:0]},
                    {exp_q[0].line, exp_q[0].mask, exp_q[0].data[31:0]});
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #400000;
        chk(1'b0, "R2 watchdog", 160'd0, 160'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!cw_valid && st_ready && !ld_hit && !ld_retry, "R1 reset state",
            {cw_valid, st_ready, ld_hit, ld_retry}, 4'b0100);

        put(32'h1000, 32'h11223344, 4'hF);   // head, line 0x100
        probe(32'h1000, 4'hF, 1, 0, 32'h11223344, "R8 forward head");
        put(32'h1004, 32'h55667788, 4'hF);   // R6: head locked, new entry
        probe(32'h1004, 4'hF, 1, 0, 32'h55667788, "R6 new entry for head line");
        probe(32'h1000, 4'hF, 0, 1, 32'h0, "R6 younger entry lacks word0");
        put(32'h1020, 32'hAAAAAAAA, 4'hF);
        put(32'h1024, 32'h1234BBCC, 4'h3);   // R5 merge
        put(32'h1020, 32'h000000EE, 4'h1);   // R5 merge single byte
        put(32'h1000, 32'h99999999, 4'hF);   // merges into younger line-0x100 entry
        probe(32'h1000, 4'hF, 1, 0, 32'h99999999, "R8 youngest match");
        probe(32'h1020, 4'hF, 1, 0, 32'hAAAAAAEE, "R5 byte overwrite");
        probe(32'h1024, 4'h3, 1, 0, 32'h0000BBCC, "R5 only enabled bytes");
        probe(32'h1024, 4'hF, 0, 1, 32'h0, "R9 partial word");
        probe(32'h1028, 4'h1, 0, 1, 32'h0, "R9 word absent in line");
        probe(32'h3000, 4'hF, 0, 0, 32'h0, "R10 miss");

        put(32'h4000, 32'h00000001, 4'hF);   // R7 outside window
        put(32'h4004, 32'h00000002, 4'hF);
        probe(32'h4004, 4'hF, 1, 0, 32'h00000002, "R7 second entry");
        probe(32'h4000, 4'hF, 0, 1, 32'h0, "R7 no merge outside window");
        put(32'h5000, 32'h3, 4'hF);
        put(32'h5010, 32'h4, 4'hF);
        put(32'h5020, 32'h5, 4'hF);          // 8 entries now

        @(posedge clk); #1;
        st_valid = 1'b1; st_waddr = 30'(32'h6000 >> 2); st_data = 32'h6; st_mask = 4'hF;
        @(negedge clk);
        chk(!st_ready, "R4 stall when full", st_ready, 1'b0);
        @(posedge clk); #1;
        st_valid = 1'b0;
        put(32'h1028, 32'h77777777, 4'hF);   // R4 merge accepted while full
        probe(32'h1028, 4'hF, 1, 0, 32'h77777777, "R4 merge while full");

        @(negedge clk);
        chk(cw_valid && cw_line == 28'h100 && cw_mask == 16'h000F &&
            cw_data[31:0] == 32'h11223344, "R3 offered head",
            {cw_valid, cw_line, cw_mask, cw_data[31:0]},
            {1'b1, 28'h100, 16'h000F, 32'h11223344});
        repeat (3) @(negedge clk);
        chk(cw_valid && cw_line == 28'h100 && cw_mask == 16'h000F &&
            cw_data[31:0] == 32'h11223344, "R3 head held while not ready",
            {cw_valid, cw_line, cw_mask, cw_data[31:0]},
            {1'b1, 28'h100, 16'h000F, 32'h11223344});
        probe(32'h4004, 4'hF, 1, 0, 32'h00000002, "R11 forward before drain");

        @(posedge clk); #1;
        cw_ready = 1'b1;
        for (int k = 0; k < 40 && exp_q.size() != 0; k++) @(negedge clk);
        @(negedge clk);
        chk(!cw_valid && exp_q.size() == 0 && st_ready, "R2 all entries drained",
            {cw_valid, st_ready, 32'(exp_q.size())}, {1'b0, 1'b1, 32'd0});
        probe(32'h4004, 4'hF, 0, 0, 32'h0, "R11 gone after drain");

        @(posedge clk); #1;
        cw_ready = 1'b0;
        put(32'h7000, 32'hCAFEF00D, 4'hF);
        @(posedge clk); #1;
        cw_ready = 1'b1;
        ld_waddr = 30'(32'h7000 >> 2); ld_mask = 4'hF;
        @(negedge clk);
        chk(ld_hit && ld_data == 32'hCAFEF00D, "R11 forward in accept cycle",
            {ld_hit, ld_data}, {1'b1, 32'hCAFEF00D});
        @(posedge clk); #1;
        cw_ready = 1'b0;
        @(negedge clk);
        chk(!cw_valid, "R3 freed after accept", cw_valid, 1'b0);
        chk(!ld_hit && !ld_retry, "R11 no forward after accept",
            {ld_hit, ld_retry}, 2'b00);
        chk(exp_q.size() == 0, "R2 single drain", 32'(exp_q.size()), 32'd0);

        summary();
        $finish;
    end
endmodule